// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Pair

This block computes 32-bit products and quotients over many clock cycles beside a processor datapath. A start command carries a two-bit operation code and two operands. The product, or the quotient and remainder, goes into a pair of dedicated result registers instead of a general register. A multiply uses a radix-2 shift-and-add loop. A divide uses a restoring shift-and-subtract loop. Both loops work on operand magnitudes, and one correction cycle at the end applies the signs.

The datapath moves values between the pair and itself with separate commands. A move-to command loads the upper or the lower register from operand A. A read request returns a registered copy of either register. A read issued while an operation is running raises `stall_o` until the result has been written, and only then is it served. Division by zero finishes in the normal number of cycles and leaves the values defined in R6.

Top module: `muldiv_unit`

## Requirements
- R1: After synchronous reset, `busy_o` and `rd_valid_o` are low, `rd_data_o` is zero, and both result registers read back as zero.
- R2: With `op_i` = 2'b00 (signed multiply), the 64-bit two's-complement product of A and B is written, with the upper word in HI and the lower word in LO.
- R3: With `op_i` = 2'b01 (unsigned multiply), the 64-bit unsigned product is written, upper word in HI and lower word in LO.
- R4: With `op_i` = 2'b10 (signed divide), LO receives the quotient truncated toward zero and HI receives the remainder, which carries the sign of A. The case -2^31 / -1 yields LO = 0x80000000 and HI = 0.
- R5: With `op_i` = 2'b11 (unsigned divide), LO receives the unsigned quotient and HI receives the remainder.
- R6: When B is zero, a divide still completes. HI receives A. LO receives 0xFFFFFFFF, except in a signed divide with negative A, where LO receives 1.
- R7: A start accepted while idle drives `busy_o` high from the next cycle, for exactly W+1 cycles (W loop steps plus one correction step). HI and LO change only at the end of that window.
- R8: A start asserted while `busy_o` is high is ignored. The running operation's result is the one written, and no further busy period follows.
- R9: While idle, `wr_hi_i` or `wr_lo_i` loads HI or LO from operand A. While busy these writes are ignored. A start in the same cycle takes priority over them.
- R10: A read request (`rd_sel_i` 0 selects LO, 1 selects HI) made while idle returns the value on `rd_data_o` with a one-cycle `rd_valid_o` pulse after the next edge. While busy, `stall_o` equals the request, no data is returned, and a held request is served after `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | 32 | Operand A (multiplicand / dividend / move-to data) |
| opb_i | input | 32 | Operand B (multiplier / divisor) |
| wr_hi_i | input | 1 | Load HI from operand A |
| wr_lo_i | input | 1 | Load LO from operand A |
| rd_req_i | input | 1 | Read request for HI or LO |
| rd_sel_i | input | 1 | Read select: 0 LO, 1 HI |
| busy_o | output | 1 | Operation in progress |
| stall_o | output | 1 | Read request held off by a running operation |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 32 | Registered read data |

## Verification
The bench targets the cases where the sign correction is easy to get wrong. These are a negative dividend with a positive divisor and the reverse, -2^31 / -1, and the all-ones operands. A design that negated the remainder by the quotient's sign, or rounded toward minus infinity, would return a wrong HI in these cases. Division by zero with both signs of dividend is checked, because a miscounted loop or missing guard would either hang `busy_o` or return an undefined LO. The bench also issues a start and a move-to in the middle of a busy period, and a read that must stall. A design that restarts, overwrites HI, or serves the read early would return a different scoreboard value or a busy window of the wrong length.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } md_state_e;
endpackage

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] acc_q;
  logic [W:0]     upper_sum;

  // add the multiplicand into the upper half when the current LSB is set
  always_comb begin
    upper_sum = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      acc_q   <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      acc_q   <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      acc_q   <= {upper_sum, acc_q[W-1:1]};
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] dvs_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] rem_q;
  logic [W:0]   rem_sh;
  logic [W:0]   trial;

  always_comb begin
    rem_sh = {rem_q, quo_q[W-1]};
    trial  = rem_sh - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvs_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      dvs_q <= dvs_i;
      quo_q <= dvd_i;
      rem_q <= '0;
    end else if (step_i) begin
      if (!trial[W]) begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= rem_sh[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // R5: partial remainder never reaches a nonzero divisor
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         wr_hi_i,
  input  logic         wr_lo_i,
  input  logic         rd_req_i,
  input  logic         rd_sel_i,
  output logic         busy_o,
  output logic         stall_o,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  md_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  md_op_e         op_q;
  logic           neg_main_q;
  logic           neg_rem_q;
  logic [W-1:0]   hi_q, lo_q;
  logic [W-1:0]   rd_data_q;
  logic           rd_valid_q;

  logic           idle;
  logic           accept;
  logic           op_signed;
  logic           a_neg, b_neg;
  logic [W-1:0]   a_mag, b_mag;
  logic           core_step;
  logic [2*W-1:0] prod_raw, prod_fix;
  logic [W-1:0]   quo_raw, rem_raw, quo_fix, rem_fix;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && start_i;
  assign op_signed = !op_i[0];
  assign a_neg     = op_signed && opa_i[W-1];
  assign b_neg     = op_signed && opb_i[W-1];
  assign a_mag     = a_neg ? (~opa_i + W'(1)) : opa_i;
  assign b_mag     = b_neg ? (~opb_i + W'(1)) : opb_i;
  assign core_step = (state_q == ST_RUN);

  md_mul_core #(.W(W)) u_mul (
    .clk      (clk),
    .rst      (rst),
    .load_i   (accept),
    .step_i   (core_step),
    .mcand_i  (a_mag),
    .mplier_i (b_mag),
    .prod_o   (prod_raw)
  );

  md_div_core #(.W(W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .step_i (core_step),
    .dvd_i  (a_mag),
    .dvs_i  (b_mag),
    .quo_o  (quo_raw),
    .rem_o  (rem_raw)
  );

  // sign correction applied in the final cycle
  assign prod_fix = neg_main_q ? (~prod_raw + (2*W)'(1)) : prod_raw;
  assign quo_fix  = neg_main_q ? (~quo_raw + W'(1)) : quo_raw;
  assign rem_fix  = neg_rem_q  ? (~rem_raw + W'(1)) : rem_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      op_q       <= OP_MULS;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q    <= ST_RUN;
          cnt_q      <= '0;
          op_q       <= md_op_e'(op_i);
          neg_main_q <= a_neg ^ b_neg;
          neg_rem_q  <= a_neg;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == LAST_STEP) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // result pair
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (state_q == ST_FIX) begin
      if (op_q[1]) begin
        hi_q <= rem_fix;
        lo_q <= quo_fix;
      end else begin
        hi_q <= prod_fix[2*W-1:W];
        lo_q <= prod_fix[W-1:0];
      end
    end else if (idle && !start_i) begin
      if (wr_hi_i) hi_q <= opa_i;
      if (wr_lo_i) lo_q <= opa_i;
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_req_i && idle;
      if (rd_req_i && idle) rd_data_q <= rd_sel_i ? hi_q : lo_q;
    end
  end

  assign busy_o     = !idle;
  assign stall_o    = rd_req_i && !idle;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  // R7: an accepted start makes the unit busy on the next cycle
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  // R7: correction step is the last busy cycle
  p_fix_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIX) |=> !busy_o);
  // R9: result pair frozen while the loop runs
  p_pair_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && state_q != ST_FIX) |=> ($stable(hi_q) && $stable(lo_q)));
  // R8: a start during busy leaves the latched operation alone
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(op_q));
  // R10: read data only follows an idle request
  p_read_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_req_i && busy_o) |=> !rd_valid_o);
endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [1:0]   op_i;
  logic [W-1:0] opa_i, opb_i;
  logic         wr_hi_i, wr_lo_i, rd_req_i, rd_sel_i;
  logic         busy_o, stall_o, rd_valid_o;
  logic [W-1:0] rd_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  muldiv_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i),
    .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i), .busy_o(busy_o),
    .stall_o(stall_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: pop the scoreboard whenever read data appears
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected read", {32'b0, rd_data_o}, 64'b0);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data_o == e, t, {32'b0, rd_data_o}, {32'b0, e});
      end
    end
  end

  // reference model
  task automatic model(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] hi, output logic [W-1:0] lo);
    longint sp;
    logic [63:0] up;
    int q, r;
    case (op)
      2'b00: begin
        sp = longint'($signed(a)) * longint'($signed(b));
        {hi, lo} = sp;
      end
      2'b01: begin
        up = {32'b0, a} * {32'b0, b};
        {hi, lo} = up;
      end
      2'b10: begin
        if (b == 0) begin
          hi = a; lo = a[W-1] ? 32'd1 : 32'hFFFF_FFFF;
        end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
          hi = 0; lo = 32'h8000_0000;
        end else begin
          q = $signed(a) / $signed(b);
          r = $signed(a) % $signed(b);
          hi = r; lo = q;
        end
      end
      default: begin
        if (b == 0) begin
          hi = a; lo = 32'hFFFF_FFFF;
        end else begin
          hi = a % b; lo = a / b;
        end
      end
    endcase
  endtask

  task automatic read_reg(input logic sel, input logic [W-1:0] expv, input string tag);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req_i = 1'b1; rd_sel_i = sel;
    @(negedge clk);
    rd_req_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy_o) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic [W-1:0] eh, el;
    int cyc;
    model(op, a, b, eh, el);
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle(cyc);
    check(cyc == W + 1, "R7 busy length", 64'(cyc), 64'(W + 1));
    read_reg(1'b0, el, {tag, " LO"});
    read_reg(1'b1, eh, {tag, " HI"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'b0, 64'b1);
    finish_up();
  end

  initial begin
    int cyc;
    rst = 1'b1; start_i = 0; op_i = 0; opa_i = 0; opb_i = 0;
    wr_hi_i = 0; wr_lo_i = 0; rd_req_i = 0; rd_sel_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(busy_o == 1'b0, "R1 busy", {63'b0, busy_o}, 64'b0);
    check(rd_valid_o == 1'b0, "R1 rd_valid", {63'b0, rd_valid_o}, 64'b0);
    check(rd_data_o == '0, "R1 rd_data", {32'b0, rd_data_o}, 64'b0);
    read_reg(1'b0, '0, "R1 reset LO");
    read_reg(1'b1, '0, "R1 reset HI");

    // R2 signed multiply
    run_op(2'b00, 32'd7, -32'sd3, "R2 7*-3");
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 -1*-1");
    // R3 unsigned multiply
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 max*max");
    run_op(2'b01, 32'h1234_5678, 32'h09AB_CDEF, "R3 pattern");
    // R4 signed divide
    run_op(2'b10, -32'sd7, 32'd2, "R4 -7/2");
    run_op(2'b10, 32'd7, -32'sd2, "R4 7/-2");
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R4 min/-1");
    run_op(2'b10, -32'sd100, -32'sd7, "R4 -100/-7");
    // R5 unsigned divide
    run_op(2'b11, 32'hFFFF_FFFF, 32'd10, "R5 max/10");
    run_op(2'b11, 32'd5, 32'd9, "R5 5/9");
    // R6 divide by zero
    run_op(2'b11, 32'd123, 32'd0, "R6 unsigned /0");
    run_op(2'b10, -32'sd5, 32'd0, "R6 signed neg /0");
    run_op(2'b10, 32'd5, 32'd0, "R6 signed pos /0");

    // R8 start during busy is ignored
    @(negedge clk);
    start_i = 1; op_i = 2'b01; opa_i = 32'd3; opb_i = 32'd4;
    @(negedge clk);
    start_i = 1; opa_i = 32'd100; opb_i = 32'd100;
    @(negedge clk);
    start_i = 0;
    wait_idle(cyc);
    check(cyc == W, "R8 busy length", 64'(cyc), 64'(W));
    @(negedge clk);
    check(busy_o == 1'b0, "R8 no restart", {63'b0, busy_o}, 64'b0);
    read_reg(1'b0, 32'd12, "R8 LO");
    read_reg(1'b1, 32'd0, "R8 HI");

    // R9 move-to while idle
    @(negedge clk);
    wr_hi_i = 1; opa_i = 32'hA5A5_0001;
    @(negedge clk);
    wr_hi_i = 0; wr_lo_i = 1; opa_i = 32'h5A5A_0002;
    @(negedge clk);
    wr_lo_i = 0;
    read_reg(1'b1, 32'hA5A5_0001, "R9 move-to HI");
    read_reg(1'b0, 32'h5A5A_0002, "R9 move-to LO");
    // R9 move-to while busy is ignored
    @(negedge clk);
    start_i = 1; op_i = 2'b01; opa_i = 32'd2; opb_i = 32'd3;
    @(negedge clk);
    start_i = 0;
    repeat (3) @(negedge clk);
    wr_hi_i = 1; wr_lo_i = 1; opa_i = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_hi_i = 0; wr_lo_i = 0;
    wait_idle(cyc);
    read_reg(1'b1, 32'd0, "R9 busy write HI");
    read_reg(1'b0, 32'd6, "R9 busy write LO");

    // R10 read during busy stalls until result ready
    @(negedge clk);
    start_i = 1; op_i = 2'b11; opa_i = 32'd1000; opb_i = 32'd7;
    @(negedge clk);
    start_i = 0;
    exp_q.push_back(32'd142);
    tag_q.push_back("R10 stalled read LO");
    rd_req_i = 1; rd_sel_i = 0;
    #1;
    check(stall_o == 1'b1, "R10 stall raised", {63'b0, stall_o}, 64'b1);
    @(negedge clk);
    check(rd_valid_o == 1'b0, "R10 no data while busy", {63'b0, rd_valid_o}, 64'b0);
    while (stall_o) @(negedge clk);
    @(negedge clk);
    rd_req_i = 0;
    @(negedge clk);
    read_reg(1'b1, 32'd6, "R10 HI after stall");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R10 scoreboard drained", 64'(exp_q.size()), 64'b0);
    finish_up();
  end
endmodule